// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Step Engine

This block advances the path metrics of a convolutional decoder by one trellis step. It keeps the accumulated metric of every trellis state internally. Each accepted transaction carries one signed branch metric per butterfly. The block then computes the updated metric of every new state and a survivor decision bit for each one. The constraint length is a parameter: 5 gives 16 states and 8 butterflies, and 7 gives 64 states and 32 butterflies. The metric is a maximising correlation. Arithmetic is signed 16-bit and saturates.

A step may ask for normalisation. In that case the smallest updated metric is found by a folded comparison tree, one tree level per clock cycle. That minimum is then subtracted from every metric before the result is presented. A start pulse puts the metrics back into the known zero-state condition. Branch metric generation, survivor storage and traceback sit outside this block.

Control is a four-state machine:
- **ST_IDLE** accepts a step or a start pulse.
- **ST_REDUCE** folds the minimum tree, one level per cycle.
- **ST_SUBTRACT** applies the minimum to all metrics.
- **ST_HOLD** presents the result until it is taken.

The transitions are:
- **accept_plain**: IDLE to HOLD.
- **accept_norm**: IDLE to REDUCE.
- **tree_done**: REDUCE to SUBTRACT after CONSTR_LEN-1 cycles.
- **sub_done**: SUBTRACT to HOLD.
- **taken**: HOLD to IDLE when out_ready_i is high.

Top module: `viterbi_acs`

## Requirements
- R1: After reset, state 0 holds metric 0 and every other state holds -16384. All decision bits are 0, out_valid_o is low and in_ready_o is high.
- R2: Metric j sits in metrics_o[16j+15:16j] and branch metric i in bm_i[16i+15:16i]. Butterfly i uses old states 2i (even) and 2i+1 (odd) with branch metric b. New state i becomes max(even+b, odd-b). New state i+S/2 becomes max(even-b, odd+b). Each step starts from the metrics left by the previous one.
- R3: Every addition and subtraction is signed 16-bit and clamps to 32767 or -32768 instead of wrapping.
- R4: Decision bit j of dec_o belongs to new state j. It is 1 when the candidate from the even predecessor is greater than or equal to the candidate from the odd predecessor, so a tie yields 1.
- R5: A step accepted with norm_i high subtracts the minimum of all updated metrics from every metric, with saturation. Every presented metric is then non-negative.
- R6: A step accepted with norm_i low stores the updated metrics unchanged.
- R7: A start_i pulse in ST_IDLE reloads the R1 metrics. While start_i is high, in_ready_o is low, so a simultaneous in_valid_i is not accepted.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o, metrics_o and dec_o stay unchanged.
- R9: in_ready_o is low from the accept edge until the result is taken. Branch metrics and norm_i presented in that time have no effect.
- R10: out_valid_o rises 1 clock edge after the accept edge for a plain step. For a normalised step it rises CONSTR_LEN+1 edges after the accept edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Reload the zero-state metrics (honoured in ST_IDLE) |
| in_valid_i | input | 1 | A step is offered |
| in_ready_o | output | 1 | A step can be accepted |
| bm_i | input | 16*S/2 | Signed branch metric per butterfly |
| norm_i | input | 1 | Normalise this step |
| out_valid_o | output | 1 | Result of a step is presented |
| out_ready_i | input | 1 | Consumer takes the result |
| metrics_o | output | 16*S | Current signed metric per state |
| dec_o | output | S | Survivor decision per new state |

## Verification
The hardest conditions to reach are saturation and exact ties, because ordinary branch metrics keep the candidates apart and well inside range. The bench restarts from the zero-state condition and then applies all-zero branch metrics. This gives every pair except the first equal odd and even candidates. It then drives full-scale branch metrics against the -16384 initial values, which pushes candidates past both rails. Normalised steps follow these, so the subtraction also sees saturated values. A behavioural model in the bench predicts every metric and decision bit.

// File: rtl/vacs_pkg.sv
package vacs_pkg;
    parameter int MW = 16;
    typedef logic signed [MW-1:0] metric_t;
    localparam metric_t MAX_M    = metric_t'((2**(MW-1)) - 1);
    localparam metric_t MIN_M    = metric_t'(-(2**(MW-1)));
    localparam metric_t INIT_NEG = metric_t'(-(2**(MW-2)));

    function automatic metric_t sat_add(metric_t a, metric_t b);
        logic signed [MW:0] s;
        s = {a[MW-1], a} + {b[MW-1], b};
        if (s[MW] != s[MW-1]) return s[MW] ? MIN_M : MAX_M;
        return s[MW-1:0];
    endfunction

    function automatic metric_t sat_sub(metric_t a, metric_t b);
        logic signed [MW:0] s;
        s = {a[MW-1], a} - {b[MW-1], b};
        if (s[MW] != s[MW-1]) return s[MW] ? MIN_M : MAX_M;
        return s[MW-1:0];
    endfunction
endpackage

// File: rtl/vacs_butterfly.sv
module vacs_butterfly
    import vacs_pkg::*;
(
    input  metric_t even_i,
    input  metric_t odd_i,
    input  metric_t bm_i,
    output metric_t upper_o,
    output metric_t lower_o,
    output logic    upper_dec_o,
    output logic    lower_dec_o
);
    metric_t up_even, up_odd, lo_even, lo_odd;

    always_comb begin
        up_even = sat_add(even_i, bm_i);
        up_odd  = sat_sub(odd_i, bm_i);
        lo_even = sat_sub(even_i, bm_i);
        lo_odd  = sat_add(odd_i, bm_i);
        // even wins ties
        upper_dec_o = (up_even >= up_odd);
        lower_dec_o = (lo_even >= lo_odd);
        upper_o = upper_dec_o ? up_even : up_odd;
        lower_o = lower_dec_o ? lo_even : lo_odd;
    end
endmodule

// File: rtl/vacs_min2.sv
module vacs_min2
    import vacs_pkg::*;
(
    input  metric_t a_i,
    input  metric_t b_i,
    output metric_t min_o
);
    assign min_o = (b_i < a_i) ? b_i : a_i;
endmodule

// File: rtl/viterbi_acs.sv
module viterbi_acs
    import vacs_pkg::*;
#(
    parameter int CONSTR_LEN = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          in_valid_i,
    output logic                          in_ready_o,
    input  logic [MW*(1<<(CONSTR_LEN-2))-1:0] bm_i,
    input  logic                          norm_i,
    output logic                          out_valid_o,
    input  logic                          out_ready_i,
    output logic [MW*(1<<(CONSTR_LEN-1))-1:0] metrics_o,
    output logic [(1<<(CONSTR_LEN-1))-1:0]    dec_o
);
    localparam int NS     = 1 << (CONSTR_LEN - 1);
    localparam int HALF   = NS / 2;
    localparam int LEVELS = CONSTR_LEN - 1;
    localparam int LW     = $clog2(LEVELS + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_REDUCE, ST_SUBTRACT, ST_HOLD} state_e;

    state_e        state_q, state_d;
    metric_t       acc_q [NS];
    metric_t       red_q [NS];
    metric_t       acs_m [NS];
    metric_t       red_d [HALF];
    metric_t       bm_v  [HALF];
    logic [NS-1:0] acs_d;
    logic [NS-1:0] dec_q;
    logic [LW-1:0] lvl_q;
    logic          norm_q;
    logic          accept;

    assign accept = in_valid_i && in_ready_o;

    // add-compare-select array, pairs drawn from even/odd old states
    for (genvar b = 0; b < HALF; b++) begin : g_bfly
        assign bm_v[b] = bm_i[b*MW +: MW];
        vacs_butterfly u_bfly (
            .even_i      (acc_q[2*b]),
            .odd_i       (acc_q[2*b+1]),
            .bm_i        (bm_v[b]),
            .upper_o     (acs_m[b]),
            .lower_o     (acs_m[b+HALF]),
            .upper_dec_o (acs_d[b]),
            .lower_dec_o (acs_d[b+HALF])
        );
    end

    // one folded level of the minimum tree
    for (genvar r = 0; r < HALF; r++) begin : g_min
        vacs_min2 u_min (
            .a_i   (red_q[2*r]),
            .b_i   (red_q[2*r+1]),
            .min_o (red_d[r])
        );
    end

    for (genvar j = 0; j < NS; j++) begin : g_out
        assign metrics_o[j*MW +: MW] = acc_q[j];
    end
    assign dec_o = dec_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = norm_i ? ST_REDUCE : ST_HOLD;
            ST_REDUCE:   if (lvl_q == LW'(LEVELS - 1)) state_d = ST_SUBTRACT;
            ST_SUBTRACT: state_d = ST_HOLD;
            ST_HOLD:     if (out_ready_i) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready_o  = (state_q == ST_IDLE) && !start_i;
        out_valid_o = (state_q == ST_HOLD);
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NS; j++) begin
                acc_q[j] <= (j == 0) ? metric_t'(0) : INIT_NEG;
                red_q[j] <= '0;
            end
            dec_q  <= '0;
            lvl_q  <= '0;
            norm_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        for (int j = 0; j < NS; j++)
                            acc_q[j] <= (j == 0) ? metric_t'(0) : INIT_NEG;
                    end else if (accept) begin
                        for (int j = 0; j < NS; j++) begin
                            acc_q[j] <= acs_m[j];
                            red_q[j] <= acs_m[j];
                        end
                        dec_q  <= acs_d;
                        lvl_q  <= '0;
                        norm_q <= norm_i;
                    end
                end
                ST_REDUCE: begin
                    for (int r = 0; r < HALF; r++) red_q[r] <= red_d[r];
                    lvl_q <= lvl_q + 1'b1;
                end
                ST_SUBTRACT: begin
                    for (int j = 0; j < NS; j++) acc_q[j] <= sat_sub(acc_q[j], red_q[0]);
                end
                default: ;
            endcase
        end
    end

    // checks
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready_o && out_valid_o)); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready_o); // R9
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(metrics_o) && $stable(dec_o)); // R8
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && state_q == ST_IDLE |=> acc_q[0] == 0 && acc_q[1] == INIT_NEG); // R7
    AST_PLAIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !norm_i |=> out_valid_o); // R10
    for (genvar j = 0; j < NS; j++) begin : g_chk
        AST_NORM_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o && norm_q |-> !acc_q[j][MW-1]); // R5
    end
endmodule

// File: tb/tb_viterbi_acs.sv
`timescale 1ns/1ps
module tb_viterbi_acs;
    localparam int K    = 7;
    localparam int NS   = 1 << (K - 1);
    localparam int HALF = NS / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, in_valid = 1'b0, norm = 1'b0, out_ready = 1'b0;
    logic [16*HALF-1:0] bm = '0;
    logic in_ready, out_valid;
    logic [16*NS-1:0] metrics;
    logic [NS-1:0] dec;

    int n_chk = 0, n_fail = 0;
    int ref_m [NS];
    bit ref_d [NS];
    int bmv [HALF];
    bit done = 0;

    always #4 clk = ~clk;

    viterbi_acs #(.CONSTR_LEN(K)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .in_valid_i(in_valid),
        .in_ready_o(in_ready), .bm_i(bm), .norm_i(norm), .out_valid_o(out_valid),
        .out_ready_i(out_ready), .metrics_o(metrics), .dec_o(dec));

    function automatic int sat16(int x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    task automatic ref_init();
        for (int j = 0; j < NS; j++) begin
            ref_m[j] = (j == 0) ? 0 : -16384;
        end
    endtask

    task automatic ref_step(input bit nrm);
        int nm [NS];
        int mn;
        for (int i = 0; i < HALF; i++) begin
            int e, o, c0, c1;
            e = ref_m[2*i]; o = ref_m[2*i+1];
            c0 = sat16(e + bmv[i]); c1 = sat16(o - bmv[i]);
            nm[i] = (c0 >= c1) ? c0 : c1; ref_d[i] = (c0 >= c1);
            c0 = sat16(e - bmv[i]); c1 = sat16(o + bmv[i]);
            nm[i+HALF] = (c0 >= c1) ? c0 : c1; ref_d[i+HALF] = (c0 >= c1);
        end
        mn = nm[0];
        for (int j = 1; j < NS; j++) if (nm[j] < mn) mn = nm[j];
        for (int j = 0; j < NS; j++) ref_m[j] = nrm ? sat16(nm[j] - mn) : nm[j];
    endtask

    function automatic logic [16*NS-1:0] exp_metrics();
        logic [16*NS-1:0] v;
        for (int j = 0; j < NS; j++) v[j*16 +: 16] = 16'(ref_m[j]);
        return v;
    endfunction

    function automatic logic [NS-1:0] exp_dec();
        logic [NS-1:0] v;
        for (int j = 0; j < NS; j++) v[j] = ref_d[j];
        return v;
    endfunction

    task automatic chk(input string req, input string what, input logic [16*NS-1:0] act,
                       input logic [16*NS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_bm(input int mode);
        for (int i = 0; i < HALF; i++) begin
            case (mode)
                0: bmv[i] = (i * 53) % 401 - 200;
                1: bmv[i] = (i % 2 == 0) ? (100 + i) : -(37 * i);
                2: bmv[i] = 0;
                3: bmv[i] = 32767;
                default: bmv[i] = -32768 + i * 5;
            endcase
            bm[i*16 +: 16] = 16'(bmv[i]);
        end
    endtask

    // one step: drive, accept, optional junk while busy, wait, compare, release
    task automatic run_step(input bit nrm, input int mode, input bit junk, input int hold,
                            input string req);
        int lat;
        logic [16*NS-1:0] snap;
        @(negedge clk);
        set_bm(mode); norm = nrm; in_valid = 1'b1;
        chk("R9", "ready before accept", {{(16*NS-1){1'b0}}, in_ready}, 1);
        @(posedge clk);
        ref_step(nrm);
        @(negedge clk);
        if (junk) begin
            set_bm(4); norm = ~nrm;   // R9: must be ignored
        end else begin
            in_valid = 1'b0;
        end
        lat = 1;
        while (!out_valid && lat < 100) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        in_valid = 1'b0; norm = 1'b0;
        chk("R10", "latency", lat, nrm ? K + 1 : 1);
        chk(req, "metrics", metrics, exp_metrics());
        chk("R4", "decisions", {{(15*NS){1'b0}}, dec}, {{(15*NS){1'b0}}, exp_dec()});
        if (hold > 0) begin
            snap = metrics;
            repeat (hold) @(negedge clk);
            chk("R8", "valid held", {{(16*NS-1){1'b0}}, out_valid}, 1);
            chk("R8", "metrics held", metrics, snap);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        chk("R9", "idle after take", {{(16*NS-2){1'b0}}, out_valid, in_ready}, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        ref_init();
        for (int j = 0; j < NS; j++) ref_d[j] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset metrics", metrics, exp_metrics());
        chk("R1", "reset handshake", {{(16*NS-2){1'b0}}, out_valid, in_ready}, 2'b01);
        chk("R1", "reset decisions", {{(15*NS){1'b0}}, dec}, '0);

        // R2 / R6 plain steps, R5 normalised steps
        run_step(1'b0, 0, 1'b0, 0, "R2");
        run_step(1'b0, 1, 1'b0, 0, "R6");
        run_step(1'b1, 0, 1'b0, 0, "R5");
        run_step(1'b0, 1, 1'b0, 0, "R2");
        run_step(1'b1, 1, 1'b0, 3, "R5");
        run_step(1'b0, 0, 1'b1, 4, "R9");
        run_step(1'b1, 0, 1'b1, 0, "R9");

        // R7 start wins over a simultaneous step
        @(negedge clk);
        start = 1'b1; in_valid = 1'b1; set_bm(0);
        #1;
        chk("R7", "ready low on start", {{(16*NS-1){1'b0}}, in_ready}, 0);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        ref_init();
        chk("R7", "reloaded metrics", metrics, exp_metrics());
        chk("R7", "no result", {{(16*NS-1){1'b0}}, out_valid}, 0);

        // R4 ties from zero branch metrics
        run_step(1'b0, 2, 1'b0, 0, "R4");
        // R3 saturation, from the start condition and again on top
        @(negedge clk); start = 1'b1; @(posedge clk); @(negedge clk); start = 1'b0;
        ref_init();
        run_step(1'b0, 3, 1'b0, 0, "R3");
        run_step(1'b0, 3, 1'b0, 0, "R3");
        run_step(1'b1, 4, 1'b0, 0, "R3");
        run_step(1'b1, 3, 1'b0, 2, "R5");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule